// File: doc/BRIEF.md
# Reference-Window Clock Frequency Meter

This block measures an unknown video clock against the known bus clock. Software writes the reference register, which opens a gate of a fixed number of bus clock cycles. While the gate is open, a counter in the video clock domain counts rising edges of the video clock. When the gate closes, the count is carried back to the bus domain as a stable held value. The reference register reads non-zero until that value has landed, so software polls it until it reads zero and then reads the video count. Software then works out the frequency from the two numbers.

A one-bit select register drives an output that chooses which of two oscillators feeds the video clock. A typical sequence is: select an oscillator, run one window, read the count, switch, and run a new window. Starting a window discards any result still in flight. The design assumes that the video clock runs faster than the bus clock, so that a one-cycle gap in the gate is always seen in the video domain.

Top module: `refwin_freq_meter`

## Requirements
- R1: After reset the reference register (offset 0x78), the video count register (offset 0x7C) and the select register (offset 0x40) all read 0, and `osc_sel` is 0.
- R2: Any write to offset 0x78 starts a window, whatever the write data. In the cycle after the write, offset 0x78 reads WIN_CYCLES (256 by default).
- R3: While a window runs, the reference readback falls by exactly one per bus clock cycle, from WIN_CYCLES down to 1, so the window lasts WIN_CYCLES bus cycles.
- R4: When the window ends, offset 0x78 reads 1 until the video count has been captured into the bus domain. It reads 0 only once offset 0x7C holds the new result.
- R5: Starting a window sets offset 0x7C to 0 in the cycle after the write.
- R6: The result held at offset 0x7C equals the number of video clock rising edges during the window, within ±3 counts of synchroniser uncertainty.
- R7: A write to offset 0x78 during a running window restarts it. The readback reloads to WIN_CYCLES, the video count restarts from zero, and the result covers only the restarted window.
- R8: A write to offset 0x78 while a finished window's result is still crossing starts a fresh window. The abandoned result never appears at offset 0x7C.
- R9: Bit 0 of a write to offset 0x40 drives `osc_sel` from the next cycle (0 selects oscillator 0, 1 selects oscillator 1). Offset 0x40 reads this bit back in bit 0, and its other bits read 0.
- R10: Once captured, the value at offset 0x7C does not change until the next window starts, even if `osc_sel` changes.
- R11: Offset 0x7C is read-only. Writes to it or to unmapped offsets have no effect, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the reference clock for the window |
| rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data for `addr` (combinational) |
| vclk | input | 1 | Video clock being measured |
| osc_sel | output | 1 | Oscillator select for the video clock source |

## Verification
The hardest case is a restart that falls in the few bus cycles after a window has closed but before its count has crossed back. Only there can a stale result be captured. The bench counts cycles from the starting write, using the exact 256-to-1 readback sequence, so that a new write lands in the first cycle of that interval. It also switches the oscillator partway through the abandoned window. A leaked stale count would then fall outside the range expected for the fresh window, and an early read during the fresh window would show a non-zero value.

// File: rtl/fm_pkg.sv
package fm_pkg;

    // Register byte offsets
    localparam logic [7:0] OFS_SEL = 8'h40;
    localparam logic [7:0] OFS_REF = 8'h78;
    localparam logic [7:0] OFS_VID = 8'h7C;

    // Bus-domain window state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } win_state_e;

    // Register write request as seen by the control logic
    typedef struct packed {
        logic       wr;
        logic [7:0] ofs;
        logic       bit0;
    } bus_req_t;

    function automatic logic req_hit(input bus_req_t r, input logic [7:0] ofs);
        return r.wr && (r.ofs == ofs);
    endfunction

endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int NST = (STAGES < 2) ? 2 : STAGES;

    logic [NST-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg <= {stg[NST-2:0], d};
        end
    end

    assign q = stg[NST-1];

endmodule

// File: rtl/fm_window.sv
module fm_window
    import fm_pkg::*;
#(
    parameter int WIN_CYCLES = 256,
    parameter int VCNT_W     = 16,
    localparam int CNT_W     = $clog2(WIN_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              done_evt,
    input  logic [VCNT_W-1:0] vid_in,
    output logic              run,
    output logic              arm_t,
    output logic [CNT_W-1:0]  ref_view,
    output logic [VCNT_W-1:0] vid_q
);
    win_state_e       st;
    logic [CNT_W-1:0] rem;
    logic             busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            rem   <= '0;
            arm_t <= 1'b0;
            vid_q <= '0;
        end else if (start) begin
            st    <= ST_RUN;
            rem   <= CNT_W'(WIN_CYCLES);
            arm_t <= ~arm_t;
            vid_q <= '0;
        end else begin
            case (st)
                ST_RUN: begin
                    if (rem == CNT_W'(1)) begin
                        st  <= ST_DRAIN;
                        rem <= '0;
                    end else begin
                        rem <= rem - 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (done_evt) begin
                        vid_q <= vid_in;
                        st    <= ST_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    assign run  = (st == ST_RUN);
    assign busy = (st != ST_IDLE);

    always_comb begin
        case (st)
            ST_RUN:   ref_view = rem;
            ST_DRAIN: ref_view = CNT_W'(1);
            default:  ref_view = '0;
        endcase
    end

    AST_WIN_LOAD: assert property (@(posedge clk) disable iff (rst)
        start |=> (run && rem == CNT_W'(WIN_CYCLES)));  // R2
    AST_WIN_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && rem > CNT_W'(1) && !start) |=> (run && rem == $past(rem) - 1'b1));  // R3
    AST_IDLE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(done_evt));  // R4
    AST_VID_CLEAR: assert property (@(posedge clk) disable iff (rst)
        start |=> (vid_q == '0));  // R5
    AST_VID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!start && !(done_evt && st == ST_DRAIN)) |=> $stable(vid_q));  // R10

endmodule

// File: rtl/fm_vcount.sv
module fm_vcount #(
    parameter int VCNT_W = 16
) (
    input  logic              vclk,
    input  logic              vrst,
    input  logic              arm_s,
    input  logic              run_s,
    output logic [VCNT_W-1:0] hold,
    output logic              done_t
);
    logic              arm_d;
    logic              run_d;
    logic              counting;
    logic [VCNT_W-1:0] cnt;
    logic              arm_evt;
    logic              stop_evt;

    assign arm_evt  = (arm_s != arm_d);
    assign stop_evt = run_d && !run_s;

    always_ff @(posedge vclk) begin
        if (vrst) begin
            arm_d    <= 1'b0;
            run_d    <= 1'b0;
            counting <= 1'b0;
            cnt      <= '0;
            hold     <= '0;
            done_t   <= 1'b0;
        end else begin
            arm_d <= arm_s;
            run_d <= run_s;
            if (arm_evt) begin
                cnt      <= '0;
                counting <= 1'b1;
            end else if (counting && stop_evt) begin
                hold     <= cnt;
                counting <= 1'b0;
                done_t   <= ~done_t;
            end else if (counting) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_STOP_HANDSHAKE: assert property (@(posedge vclk) disable iff (vrst)
        (counting && $fell(run_s) && $stable(arm_s)) |=> (done_t != $past(done_t)));  // R6
    AST_HOLD_QUIET: assert property (@(posedge vclk) disable iff (vrst)
        !counting |=> $stable(hold));  // R10

endmodule

// File: rtl/refwin_freq_meter.sv
module refwin_freq_meter
    import fm_pkg::*;
#(
    parameter int WIN_CYCLES  = 256,
    parameter int VCNT_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        vclk,
    output logic        osc_sel
);
    localparam int CNT_W = $clog2(WIN_CYCLES + 1);

    bus_req_t          req;
    logic              start;
    logic              sel_wr;
    logic              wdata_unused;

    logic              run;
    logic              arm_t;
    logic [CNT_W-1:0]  ref_view;
    logic [VCNT_W-1:0] vid_q;

    logic              vrst;
    logic              arm_s;
    logic              run_s;
    logic [VCNT_W-1:0] hold;
    logic              done_t;
    logic              done_s;
    logic              done_d;
    logic              done_evt;

    assign req          = '{wr: wr_en, ofs: addr, bit0: wdata[0]};
    assign start        = req_hit(req, OFS_REF);
    assign sel_wr       = req_hit(req, OFS_SEL);
    assign wdata_unused = ^wdata[31:1];

    // Oscillator select register
    always_ff @(posedge clk) begin
        if (rst) begin
            osc_sel <= 1'b0;
        end else if (sel_wr) begin
            osc_sel <= req.bit0;
        end
    end

    fm_window #(
        .WIN_CYCLES (WIN_CYCLES),
        .VCNT_W     (VCNT_W)
    ) u_win (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .done_evt (done_evt),
        .vid_in   (hold),
        .run      (run),
        .arm_t    (arm_t),
        .ref_view (ref_view),
        .vid_q    (vid_q)
    );

    // Reset into the video domain
    fm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_vrst (
        .clk (vclk),
        .rst (1'b0),
        .d   (rst),
        .q   (vrst)
    );

    // Start toggle and gate level into the video domain
    fm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_to_vid (
        .clk (vclk),
        .rst (vrst),
        .d   ({arm_t, run}),
        .q   ({arm_s, run_s})
    );

    fm_vcount #(.VCNT_W(VCNT_W)) u_vcnt (
        .vclk   (vclk),
        .vrst   (vrst),
        .arm_s  (arm_s),
        .run_s  (run_s),
        .hold   (hold),
        .done_t (done_t)
    );

    // Completion toggle back into the bus domain
    fm_sync #(.W(1), .STAGES(SYNC_STAGES)) u_to_bus (
        .clk (clk),
        .rst (rst),
        .d   (done_t),
        .q   (done_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_d <= 1'b0;
        end else begin
            done_d <= done_s;
        end
    end

    assign done_evt = done_s ^ done_d;

    // Register readback
    always_comb begin
        case (addr)
            OFS_REF: rdata = 32'(ref_view);
            OFS_VID: rdata = 32'(vid_q);
            OFS_SEL: rdata = {31'd0, osc_sel};
            default: rdata = '0;
        endcase
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sel_wr |=> $stable(osc_sel));  // R9
    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (rst)
        sel_wr |=> (osc_sel == $past(wdata[0])));  // R9
    AST_RO_VID: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_VID) |=> $stable(vid_q));  // R11

endmodule

// File: tb/sim_refwin_freq_meter.sv
`timescale 1ns/1ps
module sim_refwin_freq_meter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h78;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        vclk = 1'b0;
    logic        osc_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state
    int m_rem = 0;
    int m_sel = 0;

    localparam int OSC0_LO = 406, OSC0_HI = 413;  // 1024 ns / 2.5 ns = 409.6
    localparam int OSC1_LO = 338, OSC1_HI = 345;  // 1024 ns / 3.0 ns = 341.3

    refwin_freq_meter u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .vclk    (vclk),
        .osc_sel (osc_sel)
    );

    always #2 clk = ~clk;
    always #(osc_sel ? 1.5 : 1.25) vclk = ~vclk;

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input longint act, input longint lo, input longint hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h78; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic poll_zero();
        int n = 0;
        do begin
            @(negedge clk);
            addr = 8'h78;
            #1 n++;
        end while (rdata != 0 && n < 2000);
        chk("R4 window completes", (rdata == 0), 1);
    endtask

    // Cycle-by-cycle model comparison
    always @(posedge clk) begin
        if (rst) begin
            m_rem = 0;
            m_sel = 0;
        end else begin
            if (wr_en && addr == 8'h78) m_rem = 256;
            else if (m_rem > 0) m_rem--;
            if (wr_en && addr == 8'h40) m_sel = int'(wdata[0]);
        end
        #1;
        if (!rst && !done) begin
            if (addr == 8'h78 && m_rem > 0) chk("R3 window countdown", rdata, m_rem);
            chk("R9 osc_sel model", osc_sel, m_sel);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog R4: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] held;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);

        // R1 reset state
        rd(8'h78, v); chk("R1 ref after reset", v, 0);
        rd(8'h7C, v); chk("R1 vid after reset", v, 0);
        rd(8'h40, v); chk("R1 sel after reset", v, 0);
        chk("R1 osc_sel after reset", osc_sel, 0);
        rd(8'h10, v); chk("R11 unmapped reads 0", v, 0);

        // R2 start with arbitrary data, R6 oscillator 0
        wr(8'h78, 32'hDEADBEEF);
        #1 chk("R2 readback after start", rdata, 256);
        rd(8'h7C, v); chk("R5 vid zero in window", v, 0);
        poll_zero();
        rd(8'h7C, v); chk_rng("R6 R4 osc0 count", v, OSC0_LO, OSC0_HI);
        held = v;

        // R11 read-only and unmapped writes
        wr(8'h7C, 32'h0000_1234);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h7C, v); chk("R11 vid write ignored", v, held);
        rd(8'h10, v); chk("R11 unmapped write ignored", v, 0);

        // R5 start clears held count
        wr(8'h78, 0);
        rd(8'h7C, v); chk("R5 start clears vid", v, 0);
        poll_zero();
        rd(8'h7C, v); chk_rng("R6 osc0 repeat", v, OSC0_LO, OSC0_HI);

        // R9 select register
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, v); chk("R9 sel reads bit0 only", v, 1);
        chk("R9 osc_sel set", osc_sel, 1);
        wr(8'h40, 32'hFFFF_FFFE);
        rd(8'h40, v); chk("R9 sel cleared", v, 0);
        wr(8'h40, 32'h1);

        // R6 oscillator 1
        wr(8'h78, 0);
        poll_zero();
        rd(8'h7C, v); chk_rng("R6 osc1 count", v, OSC1_LO, OSC1_HI);
        held = v;

        // R10 select change leaves result
        wr(8'h40, 32'h0);
        repeat (50) @(negedge clk);
        rd(8'h7C, v); chk("R10 held after sel change", v, held);

        // R7 restart mid-window
        wr(8'h78, 0);
        repeat (100) @(negedge clk);
        wr(8'h78, 0);
        #1 chk("R7 restart reloads", rdata, 256);
        poll_zero();
        rd(8'h7C, v); chk_rng("R7 restarted window count", v, OSC0_LO, OSC0_HI);

        // R8 restart in the drain interval, oscillator switched mid-window
        wr(8'h40, 32'h1);
        wr(8'h78, 0);
        repeat (200) @(negedge clk);
        wr(8'h40, 32'h0);
        repeat (54) @(negedge clk);
        #1 chk("R4 drain reads 1", rdata, 1);
        wr_en = 1'b1; addr = 8'h78; wdata = '0;
        @(negedge clk);
        wr_en = 1'b0;
        #1 chk("R8 restart from drain", rdata, 256);
        repeat (30) @(negedge clk);
        rd(8'h7C, v); chk("R8 stale result discarded", v, 0);
        poll_zero();
        rd(8'h7C, v); chk_rng("R8 fresh window count", v, OSC0_LO, OSC0_HI);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule